// File: doc/BRIEF.md
# Input Delay Eye-Window Calibrator

This block tunes the input delay of one serial lane so that the lane's deserializer samples in the middle of its data eye. It owns a 6-bit delay tap that it drives out to a tap-indexed delay line. Each time an operator or sequencer raises the step request, the tap moves up by one position, with wrap-around at the top of the range. After each step the block waits a short settle interval and then compares the deserialized 7-bit lane word with an expected pattern.

The block counts the steps it has taken. The count at which the lane first delivers the expected word is the low edge of the window, N. The count at which the match is first lost after that is the high edge, M. The block reports the window width as M-N and the centre tap as the integer part of (M+N-1)/2. It then loads that centre into the tap output, where it stays fixed. Stepping only proceeds while the clock generator reports lock and the delay reference reports ready. A lane that matches on every one of the 64 taps is reported as a saturated window. To cover several lanes, one copy of the block is placed per lane.

Top module: `eye_window_cal`

## Requirements
- R1: After reset, the tap output is 0, the done and saturated flags are 0, and the width and centre outputs are 0.
- R2: Each rising edge of the synchronized step request advances the tap by exactly one while the block is enabled and still searching. A request held high for several cycles counts as a single step.
- R3: A step taken at tap 63 returns the tap to 0.
- R4: While either the lock input or the ready input is low, step requests are ignored and the tap and done flag do not change.
- R5: The whole 7-bit lane word is compared with the expected-pattern input. During calibration that pattern is 7'b0000001, and a word with any other bit set is a mismatch. N is the step count, starting at 0 with no steps taken, at which the first match is seen.
- R6: M is the first step count after N that gives a mismatch. The done flag rises once exactly M steps have been taken, and the width output is then M-N.
- R7: When done rises, the centre output and the tap output both equal floor((M+N-1)/2) modulo 64.
- R8: If the lane still matches 64 steps after N, the saturated flag and the done flag are set, M is taken as N+64, the width is 64, and the centre is (N+31) modulo 64.
- R9: Once done is set, further step requests are ignored. The tap, width and centre hold.
- R10: If the lane never matches, the block keeps searching: done stays 0 and the tap keeps wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | Clock generator lock indication |
| dly_ready | input | 1 | Delay reference calibration ready |
| step_req | input | 1 | Asynchronous step request, edge-counted |
| lane_data | input | 7 | Deserialized lane word |
| expect_pat | input | 7 | Word the lane must present to pass |
| tap_out | output | 6 | Delay tap setting for the delay line |
| win_width | output | 7 | Window width M-N |
| win_center | output | 6 | Computed centre tap |
| win_sat | output | 1 | Window spans every tap |
| cal_done | output | 1 | Calibration finished, centre loaded |

## Verification
On every cycle the assertions check the following: the tap moves only by +1 while searching, nothing moves while lock or ready is low, and the tap loaded when done rises equals the reported centre. They also check that the outputs freeze once done is set, and that the width stays in range and reads 64 whenever the window is flagged saturated. The values of N, M, the width and the centre can only be shown by the bench's scenarios. These run a modelled delay line whose pass window has a chosen start and length, including windows that wrap through tap 0, windows that end at tap 63, full windows and empty windows. In each scenario the number of steps needed to reach done is compared with an independently computed M.

// File: rtl/eye_window_cal.sv
module eye_window_cal #(
  parameter int TAP_BITS    = 6,
  parameter int DATA_W      = 7,
  parameter int SETTLE      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pll_locked,
  input  logic                dly_ready,
  input  logic                step_req,
  input  logic [DATA_W-1:0]   lane_data,
  input  logic [DATA_W-1:0]   expect_pat,
  output logic [TAP_BITS-1:0] tap_out,
  output logic [TAP_BITS:0]   win_width,
  output logic [TAP_BITS-1:0] win_center,
  output logic                win_sat,
  output logic                cal_done
);
  localparam int NTAPS = 1 << TAP_BITS;
  localparam int CNT_W = TAP_BITS + 1;
  localparam int SET_W = $clog2(SETTLE + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_EVAL, S_WAIT, S_DONE} state_t;

  state_t                 state;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   step_prev;
  logic [SET_W-1:0]       settle_cnt;
  logic [CNT_W-1:0]       cnt, n_q;
  logic                   found;
  logic [CNT_W:0]         sum;
  logic [TAP_BITS-1:0]    ctap;

  wire en        = pll_locked & dly_ready;
  wire step_edge = sync_q[SYNC_STAGES-1] & ~step_prev;
  wire match     = (lane_data == expect_pat);
  wire top_hit   = (cnt == CNT_W'(n_q + NTAPS));

  assign sum  = {1'b0, cnt} + {1'b0, n_q} - 1'b1;
  assign ctap = TAP_BITS'(sum >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      step_prev <= 1'b0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], step_req};
      step_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      settle_cnt <= '0;
      tap_out    <= '0;
      cnt        <= '0;
      n_q        <= '0;
      found      <= 1'b0;
      win_width  <= '0;
      win_center <= '0;
      win_sat    <= 1'b0;
      cal_done   <= 1'b0;
    end else if (en) begin
      case (state)
        S_IDLE: begin
          state      <= S_SETTLE;
          settle_cnt <= '0;
        end
        S_SETTLE: begin
          if (settle_cnt == SET_W'(SETTLE - 1)) state <= S_EVAL;
          else settle_cnt <= settle_cnt + 1'b1;
        end
        S_EVAL: begin
          if (!found) begin
            if (match) begin
              found <= 1'b1;
              n_q   <= cnt;
            end
            state <= S_WAIT;
          end else if (!match || top_hit) begin
            win_width  <= cnt - n_q;
            win_center <= ctap;
            tap_out    <= ctap;
            win_sat    <= match;
            cal_done   <= 1'b1;
            state      <= S_DONE;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (step_edge) begin
            tap_out    <= tap_out + 1'b1;
            cnt        <= (!found && cnt == CNT_W'(NTAPS - 1)) ? '0 : cnt + 1'b1;
            settle_cnt <= '0;
            state      <= S_SETTLE;
          end
        end
        default: state <= S_DONE;
      endcase
    end
  end
endmodule

// File: rtl/eye_window_cal_chk.sv
module eye_window_cal_chk #(
  parameter int TAP_BITS = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pll_locked,
  input logic                dly_ready,
  input logic [TAP_BITS-1:0] tap_out,
  input logic [TAP_BITS:0]   win_width,
  input logic [TAP_BITS-1:0] win_center,
  input logic                win_sat,
  input logic                cal_done
);
  AST_TAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_done && tap_out != $past(tap_out)) |-> tap_out == TAP_BITS'($past(tap_out) + 1'b1)); // R2 R3

  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_done && !(pll_locked && dly_ready)) |=> ($stable(tap_out) && $stable(cal_done))); // R4

  AST_DONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> tap_out == win_center); // R7

  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> (cal_done && $stable(tap_out) && $stable(win_center) && $stable(win_width))); // R9

  AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (win_width != 0 && win_width <= (TAP_BITS + 1)'(1 << TAP_BITS))); // R6

  AST_SAT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    win_sat |-> (cal_done && win_width == (TAP_BITS + 1)'(1 << TAP_BITS))); // R8
endmodule

bind eye_window_cal eye_window_cal_chk #(.TAP_BITS(TAP_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .dly_ready(dly_ready),
  .tap_out(tap_out), .win_width(win_width), .win_center(win_center),
  .win_sat(win_sat), .cal_done(cal_done)
);

// File: tb/sim_eye_window_cal.sv
module sim_eye_window_cal;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_locked = 1'b0, dly_ready = 1'b0, step_req = 1'b0;
  logic [6:0] lane_data, expect_pat = 7'b0000001, bad_word = 7'b0000011;
  logic [5:0] tap_out, win_center;
  logic [6:0] win_width;
  logic       win_sat, cal_done;
  int         win_lo = 0, win_len = 0;
  int         checks = 0, errors = 0;
  int         cycles = 0;

  always #4 clk = ~clk;

  eye_window_cal u0 (
    .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .dly_ready(dly_ready),
    .step_req(step_req), .lane_data(lane_data), .expect_pat(expect_pat),
    .tap_out(tap_out), .win_width(win_width), .win_center(win_center),
    .win_sat(win_sat), .cal_done(cal_done)
  );

  function automatic bit in_win(int t, int lo, int len);
    return len > 0 && ((t - lo + 64) % 64) < len;
  endfunction

  always_comb lane_data = in_win(int'(tap_out), win_lo, win_len) ? 7'b0000001 : bad_word;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ref_cal(input int lo, input int len, output int n, output int m, output bit sat);
    bit f = 0;
    n = 0; m = 0; sat = 0;
    for (int c = 0; c < 200; c++) begin
      bit mt = in_win(c % 64, lo, len);
      if (!f) begin
        if (mt) begin f = 1; n = c; end
      end else if (!mt || c == n + 64) begin
        m = c; sat = mt; break;
      end
    end
  endtask

  task automatic pulse(int hold);
    @(negedge clk) step_req = 1'b1;
    repeat (hold) @(negedge clk);
    step_req = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic restart(int lo, int len);
    rst_n = 1'b0; pll_locked = 1'b0; dly_ready = 1'b0; step_req = 1'b0;
    win_lo = lo; win_len = len;
    case ($urandom % 4)
      0: bad_word = 7'b0000000;
      1: bad_word = 7'b0000011;
      2: bad_word = 7'b1000001;
      default: bad_word = 7'b1111111;
    endcase
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_cal(int lo, int len);
    int n, m, p;
    bit sat;
    ref_cal(lo, len, n, m, sat);
    restart(lo, len);
    pll_locked = 1'b1; dly_ready = 1'b1;
    repeat (10) @(negedge clk);
    p = 0;
    while (!cal_done && p < 140) begin
      pulse(1 + $urandom % 4);
      p++;
      if (!cal_done) check("R2/R3 tap after step", int'(tap_out), p % 64);
    end
    check("R6 steps to done equals M", p, m);
    check("R5/R6 width M-N", int'(win_width), m - n);
    check("R7 centre", int'(win_center), ((m + n - 1) / 2) % 64);
    check("R7 tap loaded", int'(tap_out), ((m + n - 1) / 2) % 64);
    check("R8 saturated flag", int'(win_sat), int'(sat));
    pulse(2);
    check("R9 tap holds after done", int'(tap_out), ((m + n - 1) / 2) % 64);
    check("R9 width holds after done", int'(win_width), m - n);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1 reset state
    restart(5, 8);
    check("R1 tap", int'(tap_out), 0);
    check("R1 done", int'(cal_done), 0);
    check("R1 sat", int'(win_sat), 0);
    check("R1 width", int'(win_width), 0);
    check("R1 centre", int'(win_center), 0);
    // R4 gating before enable
    pulse(2);
    check("R4 no lock no ready", int'(tap_out), 0);
    dly_ready = 1'b1;
    pulse(2);
    check("R4 ready without lock", int'(tap_out), 0);
    dly_ready = 1'b0; pll_locked = 1'b1;
    pulse(2);
    check("R4 lock without ready", int'(tap_out), 0);
    dly_ready = 1'b1;
    repeat (10) @(negedge clk);
    // R2 long hold counts once
    pulse(6);
    check("R2 held request one step", int'(tap_out), 1);
    dly_ready = 1'b0;
    pulse(3);
    check("R4 mid-search gated", int'(tap_out), 1);
    dly_ready = 1'b1;
    repeat (5) @(negedge clk);
    pulse(1);
    check("R2 step after re-enable", int'(tap_out), 2);

    // R10 no window: keep searching, tap wraps (R3)
    restart(0, 0);
    pll_locked = 1'b1; dly_ready = 1'b1;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 70; i++) pulse(1);
    check("R10 not done", int'(cal_done), 0);
    check("R3 wrapped tap", int'(tap_out), 70 % 64);

    // directed windows
    run_cal(5, 8);
    run_cal(0, 1);
    run_cal(60, 10);
    run_cal(63, 3);
    run_cal(50, 14);
    run_cal(62, 2);
    run_cal(40, 64);   // R8 full window
    run_cal(63, 1);

    // constrained random windows
    for (int k = 0; k < 12; k++) run_cal($urandom % 64, 1 + $urandom % 64);

    finish_run();
  end
endmodule